// File: doc/BRIEF.md
# Prioritized Masked Interrupt Resolver

This block sits between a group of hardware interrupt sources and a processor core. Each of five request lines is captured into a sticky pending bit. That bit stays set until software acknowledges that level, even while the level is masked or interrupts are globally off. The pending bits are combined with a per-level enable mask and with a current in-service threshold. The block then asserts a single request to the core, together with the number of the most urgent level that may run now.

The in-service threshold is what lets the handlers nest. Acknowledging a level makes it the in-service level, so that level and every lower one are held off, and only strictly higher levels can interrupt the running handler. A completion pulse from the handler pops a small stack of saved thresholds, one entry per level. This restores the level that was interrupted, or the idle state. Level 4 is the most urgent and level 0 the least.

Top module: `irq_resolver`

## Requirements
- R1: After reset the pending vector is all zero, `req_o` is 0, `sel_lvl_o` is 0 and no level is in service.
- R2: A 1 on `irq_i[k]` sets `pend_o[k]` from the next clock edge on; the bit then stays set whatever `mask_i` and `gie_i` are, until it is acknowledged.
- R3: `req_o` is 1 exactly when `gie_i` is 1 and some level k has `pend_o[k]`=1, `mask_i[k]`=1 and k strictly above the in-service level (any k when idle); it reacts combinationally to `mask_i` and `gie_i`.
- R4: While `req_o` is 1, `sel_lvl_o` is the binary number of the highest-numbered level that qualifies under R3; while `req_o` is 0, `sel_lvl_o` is 0.
- R5: `ack_i`=1 with `ack_lvl_i`=k (k<5) clears `pend_o[k]` at the next edge, unless `irq_i[k]` is 1 in the same cycle, in which case the bit stays 1; an `ack_lvl_i` of 5 or more changes nothing.
- R6: An acknowledge of level k that is strictly above the in-service level (or any valid k when idle) saves the current state on the stack and makes k the in-service level, which blocks levels k and below.
- R7: A `done_i` pulse restores the in-service state that was saved by the most recent accepted acknowledge; `done_i` with nothing in service has no effect.
- R8: When an accepted acknowledge and `done_i` arrive in the same cycle, the acknowledge takes effect and `done_i` is ignored.
- R9: An acknowledge of a level at or below the in-service level clears its pending bit only and leaves the in-service level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 5 | Interrupt request per level, bit k is level k |
| mask_i | input | 5 | Per-level enable, 1 allows the level |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged |
| done_i | input | 1 | Handler completion strobe |
| pend_o | output | 5 | Sticky pending bits |
| req_o | output | 1 | Interrupt request to the core |
| sel_lvl_o | output | 3 | Selected level, valid while req_o is 1 |

## Verification
The bench drives a request on a level while it is acknowledged in the same cycle. A design that lets the clear win would lose that edge, and the level would never be requested again. It checks that a new request at the in-service level stays quiet while a higher level breaks through, and that two completions walk back through a nested pair of levels to idle. A stack that was not kept would jump straight to idle and re-enable the lower levels too early. The bench also covers an acknowledge arriving together with a completion, an acknowledge at a lower level, an out-of-range acknowledge number and a completion on an empty stack. Each of these leaves a wrong threshold behind, and that threshold shows on `req_o` as soon as a lower level becomes pending.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  parameter int unsigned NUM_LVL = 5;
  localparam int unsigned SEL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam int unsigned THR_W = $clog2(NUM_LVL + 1);

  typedef logic [NUM_LVL-1:0] lvl_vec_t;
  typedef logic [SEL_W-1:0]   lvl_idx_t;
  // 0 = idle, k+1 = level k in service
  typedef logic [THR_W-1:0]   thr_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_res_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_vec_t irq_i,
  input  logic     ack_i,
  input  lvl_idx_t ack_lvl_i,
  output lvl_vec_t pend_o
);
  lvl_vec_t pend_q;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    logic clr;
    assign clr = ack_i && (ack_lvl_i == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           pend_q[k] <= 1'b0;
      else if (irq_i[k])     pend_q[k] <= 1'b1;  // new request beats clear
      else if (clr)          pend_q[k] <= 1'b0;
    end

    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[k] |=> pend_q[k]);
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[k] && !clr) |=> pend_q[k]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !irq_i[k]) |=> !pend_q[k]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_res_pkg::*;
(
  input  lvl_vec_t pend_i,
  input  lvl_vec_t mask_i,
  input  thr_t     thr_i,
  output logic     any_o,
  output lvl_idx_t sel_o
);
  lvl_vec_t cand;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_cand
    assign cand[k] = pend_i[k] && mask_i[k] && (THR_W'(k) >= thr_i);
  end

  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (cand[k]) sel_o = SEL_W'(k);  // later index overrides: highest wins
    end
  end

  assign any_o = |cand;
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
  import irq_res_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ack_i,
  input  lvl_idx_t ack_lvl_i,
  input  logic     done_i,
  output thr_t     thr_o
);
  thr_t thr_q, sp_q, top;
  thr_t stk_q [NUM_LVL];
  logic lvl_ok, accept, pop;

  assign lvl_ok = {1'b0, ack_lvl_i} < (SEL_W + 1)'(NUM_LVL);
  assign accept = ack_i && lvl_ok && (THR_W'(ack_lvl_i) >= thr_q)
                  && (sp_q < THR_W'(NUM_LVL));
  assign pop    = done_i && !accept && (sp_q != '0);

  for (genvar e = 0; e < NUM_LVL; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           stk_q[e] <= '0;
      else if (accept && sp_q == THR_W'(e))  stk_q[e] <= thr_q;
    end
  end

  always_comb begin
    top = '0;
    for (int e = 0; e < NUM_LVL; e++) begin
      if (sp_q == THR_W'(e + 1)) top = stk_q[e];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
      sp_q  <= '0;
    end else if (accept) begin
      thr_q <= THR_W'(ack_lvl_i) + THR_W'(1);
      sp_q  <= sp_q + THR_W'(1);
    end else if (pop) begin
      thr_q <= top;
      sp_q  <= sp_q - THR_W'(1);
    end
  end

  assign thr_o = thr_q;

  p_push_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (thr_q > $past(thr_q)));
  p_pop_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (thr_q < $past(thr_q)));
  p_empty_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ack_i && sp_q == '0) |=> $stable(thr_q));
  p_ack_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && done_i) |=> (sp_q == $past(sp_q) + THR_W'(1)));
  p_low_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !done_i && thr_q != '0 && THR_W'(ack_lvl_i) < thr_q) |=> $stable(thr_q));
  p_sp_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= THR_W'(NUM_LVL));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LVL-1:0]   irq_i,
  input  logic [NUM_LVL-1:0]   mask_i,
  input  logic                 gie_i,
  input  logic                 ack_i,
  input  logic [SEL_W-1:0]     ack_lvl_i,
  input  logic                 done_i,
  output logic [NUM_LVL-1:0]   pend_o,
  output logic                 req_o,
  output logic [SEL_W-1:0]     sel_lvl_o
);
  lvl_vec_t pend;
  thr_t     thr;
  logic     any;
  lvl_idx_t sel;

  irq_pend_bank u_pend (
    .clk_i, .rst_ni, .irq_i, .ack_i, .ack_lvl_i, .pend_o(pend)
  );

  irq_prio_stack u_stack (
    .clk_i, .rst_ni, .ack_i, .ack_lvl_i, .done_i, .thr_o(thr)
  );

  irq_prio_pick u_pick (
    .pend_i(pend), .mask_i, .thr_i(thr), .any_o(any), .sel_o(sel)
  );

  assign pend_o    = pend;
  assign req_o     = gie_i && any;
  assign sel_lvl_o = req_o ? sel : '0;

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (gie_i && |(pend_o & mask_i)));
  p_sel_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend_o[sel_lvl_o] && mask_i[sel_lvl_o]));
  p_sel_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (sel_lvl_o == '0));
endmodule

// File: tb/tb_irq_resolver.sv
module tb_irq_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 35;

  typedef struct packed {
    logic [4:0] irq;
    logic [4:0] mask;
    logic       gie;
    logic       ack;
    logic [2:0] alvl;
    logic       done;
    logic [4:0] epend;
    logic       ereq;
    logic [2:0] esel;
    logic [3:0] rq;
  } vec_t;

  // irq mask gie ack alvl done | pend req sel | req tag
  localparam vec_t VECS [NV] = '{
    '{5'b00100, 5'b11111, 1'b0, 1'b0, 3'd0, 1'b0, 5'b00100, 1'b0, 3'd0, 4'd2}, // R2 latched, gie off
    '{5'b00000, 5'b11011, 1'b1, 1'b0, 3'd0, 1'b0, 5'b00100, 1'b0, 3'd0, 4'd2}, // R2 kept while masked
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b00100, 1'b1, 3'd2, 4'd3}, // R3
    '{5'b01001, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b01101, 1'b1, 3'd3, 4'd4}, // R4 highest
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd3, 1'b0, 5'b00101, 1'b0, 3'd0, 4'd6}, // R6 enter 3
    '{5'b01000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b01101, 1'b0, 3'd0, 4'd6}, // R6 same level blocked
    '{5'b10000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b11101, 1'b1, 3'd4, 4'd6}, // R6 higher preempts
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd4, 1'b0, 5'b01101, 1'b0, 3'd0, 4'd6}, // R6 enter 4
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b01101, 1'b0, 3'd0, 4'd7}, // R7 back to 3
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b01101, 1'b1, 3'd3, 4'd7}, // R7 back to idle
    '{5'b01000, 5'b11111, 1'b1, 1'b1, 3'd3, 1'b0, 5'b01101, 1'b0, 3'd0, 4'd5}, // R5 set beats clear
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b01101, 1'b1, 3'd3, 4'd7}, // R7
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd3, 1'b0, 5'b00101, 1'b0, 3'd0, 4'd5}, // R5 clear
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00101, 1'b1, 3'd2, 4'd7}, // R7
    '{5'b00000, 5'b00001, 1'b1, 1'b0, 3'd0, 1'b0, 5'b00101, 1'b1, 3'd0, 4'd4}, // R4 mask picks
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd0, 1'b0, 5'b00100, 1'b1, 3'd2, 4'd6}, // R6 in 0, 2 preempts
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd2, 1'b0, 5'b00000, 1'b0, 3'd0, 4'd6}, // R6 nest 2
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00000, 1'b0, 3'd0, 4'd7}, // R7 pop to 0
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00000, 1'b0, 3'd0, 4'd7}, // R7 pop to idle
    '{5'b00001, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00001, 1'b1, 3'd0, 4'd7}, // R7 done on empty
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd0, 1'b0, 5'b00000, 1'b0, 3'd0, 4'd5}, // R5
    '{5'b00010, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00010, 1'b1, 3'd1, 4'd7}, // R7
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd6, 1'b0, 5'b00010, 1'b1, 3'd1, 4'd5}, // R5 bad level
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd1, 1'b1, 5'b00000, 1'b0, 3'd0, 4'd8}, // R8 ack+done
    '{5'b00001, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b00001, 1'b0, 3'd0, 4'd8}, // R8 level 1 held
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00001, 1'b1, 3'd0, 4'd8}, // R8
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd0, 1'b0, 5'b00000, 1'b0, 3'd0, 4'd5}, // R5
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00000, 1'b0, 3'd0, 4'd7}, // R7
    '{5'b00011, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b00011, 1'b1, 3'd1, 4'd4}, // R4
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd1, 1'b0, 5'b00001, 1'b0, 3'd0, 4'd6}, // R6
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd0, 1'b0, 5'b00000, 1'b0, 3'd0, 4'd9}, // R9 low ack
    '{5'b00010, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b0, 5'b00010, 1'b0, 3'd0, 4'd9}, // R9 still at 1
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00010, 1'b1, 3'd1, 4'd9}, // R9 single pop
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 3'd1, 1'b0, 5'b00000, 1'b0, 3'd0, 4'd5}, // R5
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0, 1'b1, 5'b00000, 1'b0, 3'd0, 4'd7}  // R7
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] irq_i = '0, mask_i = '0;
  logic       gie_i = 1'b0, ack_i = 1'b0, done_i = 1'b0;
  logic [2:0] ack_lvl_i = '0;
  logic [4:0] pend_o;
  logic       req_o;
  logic [2:0] sel_lvl_o;

  int n_chk = 0;
  int n_bad = 0;

  irq_resolver dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic check(input int rq, input logic [4:0] ep, input logic er,
                       input logic [2:0] es, input string what);
    n_chk++;
    if (pend_o !== ep || req_o !== er || sel_lvl_o !== es) begin
      n_bad++;
      $display("FAIL R%0d %s: pend=%b req=%b sel=%0d expected pend=%b req=%b sel=%0d",
               rq, what, pend_o, req_o, sel_lvl_o, ep, er, es);
    end
  endtask

  task automatic apply(input vec_t v);
    irq_i = v.irq; mask_i = v.mask; gie_i = v.gie;
    ack_i = v.ack; ack_lvl_i = v.alvl; done_i = v.done;
  endtask

  task automatic idle_in();
    irq_i = '0; ack_i = 1'b0; ack_lvl_i = '0; done_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all R): run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    gie_i = 1'b1; mask_i = 5'b11111;
    check(1, 5'b00000, 1'b0, 3'd0, "in reset");  // R1
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, 5'b00000, 1'b0, 3'd0, "after reset");  // R1

    apply(VECS[0]);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      check(int'(VECS[k].rq), VECS[k].epend, VECS[k].ereq, VECS[k].esel,
            $sformatf("vector %0d", k));
      if (k + 1 < NV) apply(VECS[k + 1]);
    end
    idle_in();

    // R3: gie and mask gate the request combinationally
    irq_i = 5'b01000;
    @(negedge clk_i);
    irq_i = '0;
    #1 check(3, 5'b01000, 1'b1, 3'd3, "pending level 3");
    gie_i = 1'b0;
    #1 check(3, 5'b01000, 1'b0, 3'd0, "gie dropped");
    gie_i = 1'b1; mask_i = 5'b10111;
    #1 check(3, 5'b01000, 1'b0, 3'd0, "level 3 masked");
    mask_i = 5'b11111;

    // R1: reset mid-nest clears pending and in-service state
    ack_i = 1'b1; ack_lvl_i = 3'd3; irq_i = 5'b00011;
    @(negedge clk_i);
    idle_in();
    check(6, 5'b00011, 1'b0, 3'd0, "levels below 3 blocked");  // R6
    rst_ni = 1'b0;
    #1 check(1, 5'b00000, 1'b0, 3'd0, "async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    irq_i = 5'b00001;
    @(negedge clk_i);
    irq_i = '0;
    check(1, 5'b00001, 1'b1, 3'd0, "idle after reset");

    finish_run();
  end
endmodule